// File: doc/BRIEF.md
# Auto-Reload Timer PWM Generator

This block turns a 32-bit up counter into a single PWM output line. The counter counts prescaled ticks. When it reaches all ones it raises an overflow event and reloads from a load value, so one period lasts (0xFFFFFFFF - load + 1) ticks. When compare is enabled, a match event fires as the counter passes a programmed match value. The output does not follow a comparator. Instead it reacts to the chosen events: it either inverts on each one, or emits a single-clock pulse away from its rest level. The rest level is programmable, and it sets the waveform polarity.

Software programs the load and match values, the prescaler, the event selection, the output style and the rest level. It then starts the timer, optionally after presetting the counter near the top so that an overflow comes first. The timer runs continuously in auto-reload mode, or stops after the first overflow in one-shot mode. Sticky overflow and match flags with separate enables feed one interrupt line. A configuration check flags load and match settings that would break the waveform.

Top module: `arpwm_timer`

## Requirements
- R1: While running, each counting tick advances the counter by one. On a tick with the counter at 0xFFFFFFFF an overflow event occurs and the counter reloads from the load value. In toggle mode with overflow-only events, the output therefore inverts every (0xFFFFFFFF - load + 1) ticks.
- R2: With the prescaler enabled and `div_sel` = n (0..8, larger values treated as 8), one tick occurs every 2^n clocks. With the prescaler disabled, one tick occurs every clock.
- R3: A match event occurs on a tick where the counter equals the active match value, and only while `cmp_en` is 1.
- R4: `trig_sel` encoding: 2'b00 = no output events, 2'b01 = overflow only, 2'b10 = overflow and match, 2'b11 = no output events.
- R5: With `pulse_mode` = 1, each selected event drives the output to the inverse of `idle_lvl` for exactly one clock. With `pulse_mode` = 0, each selected event inverts the output.
- R6: While the timer is stopped, the output takes the value of `idle_lvl` one clock later.
- R7: A `cnt_wr` strobe loads `cnt_wdata` into the counter. Preloading 0xFFFFFFFE makes an overflow the first event after start.
- R8: With `auto_rld` = 1 the timer keeps running across overflows. With `auto_rld` = 0 it stops at the first overflow (`running` falls).
- R9: `cfg_err` is 1 whenever the written load or match value exceeds 0xFFFFFFFD, or when `trig_sel` = 2'b10 and the match value is less than load + 2.
- R10: Values written with `ld_wr` while the timer runs take effect at the next overflow: the period in progress keeps its length. While the timer is stopped, they take effect at once.
- R11: `ovf_flag` and `mat_flag` set on their events and hold until a 1 on `ovf_clr` or `mat_clr` clears them, with set winning over clear. `irq` = (`ovf_flag` and `ovf_ie`) or (`mat_flag` and `mat_ie`).
- R12: After reset, the output, `running`, both flags, `irq` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe (wins over stop) |
| stop | input | 1 | Stop strobe |
| auto_rld | input | 1 | 1 = continuous, 0 = one-shot |
| pre_en | input | 1 | Prescaler enable |
| div_sel | input | 4 | Prescaler exponent n |
| cmp_en | input | 1 | Compare (match) enable |
| trig_sel | input | 2 | Output event selection |
| pulse_mode | input | 1 | 1 = pulse, 0 = toggle |
| idle_lvl | input | 1 | Output rest level |
| ld_wr | input | 1 | Write strobe for load and match values |
| ld_val | input | 32 | Load value |
| mt_val | input | 32 | Match value |
| cnt_wr | input | 1 | Counter preset strobe |
| cnt_wdata | input | 32 | Counter preset value |
| ovf_ie | input | 1 | Overflow interrupt enable |
| mat_ie | input | 1 | Match interrupt enable |
| ovf_clr | input | 1 | Clear overflow flag (write 1) |
| mat_clr | input | 1 | Clear match flag (write 1) |
| pwm_out | output | 1 | PWM output line |
| running | output | 1 | Timer running |
| ovf_flag | output | 1 | Sticky overflow flag |
| mat_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Combined interrupt request |
| cfg_err | output | 1 | Invalid load/match configuration |

## Verification
A corrupted counter or reload value shows up at the port as a wrong spacing between output edges, starting with the first period after the fault. The bench therefore measures every edge-to-edge interval and compares it with the intervals predicted from the load and match values. A stale match value, or a shadow value applied too early, changes the interval pair of the period in progress or the next period, so it is visible within two periods. Errors in the run state or the flags show within a few clocks on `running`, `pwm_out` at rest, and `irq`.

// File: rtl/arpwm_pkg.sv
package arpwm_pkg;
  typedef enum logic [1:0] {
    TRG_NONE = 2'b00,
    TRG_OVF  = 2'b01,
    TRG_BOTH = 2'b10,
    TRG_RSV  = 2'b11
  } trig_e;
endpackage

// File: rtl/arpwm_presc.sv
module arpwm_presc #(
  parameter int SELW = 4,
  parameter int NMAX = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            pre_en_i,
  input  logic [SELW-1:0] sel_i,
  output logic            tick_o
);
  localparam int PCW = (NMAX > 0) ? NMAX : 1;

  logic [PCW-1:0] pc_q, pc_d;
  logic [SELW-1:0] sel_c;
  logic [PCW:0]   lim_w;
  logic           wrap;

  always_comb begin
    sel_c = (int'(sel_i) > NMAX) ? SELW'(NMAX) : sel_i;
    lim_w = ({{PCW{1'b0}}, 1'b1} << sel_c) - 1'b1;
    wrap  = (pc_q == lim_w[PCW-1:0]);
    tick_o = en_i && (!pre_en_i || wrap);
    if (!en_i || !pre_en_i) pc_d = '0;
    else if (wrap)          pc_d = '0;
    else                    pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R2: with the prescaler bypassed, every running clock is a tick
  presc_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !pre_en_i) |-> tick_o);
endmodule

// File: rtl/arpwm_count.sv
module arpwm_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          auto_i,
  input  logic          cmp_en_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          ld_wr_i,
  input  logic [CW-1:0] ld_val_i,
  input  logic [CW-1:0] mt_val_i,
  output logic          run_o,
  output logic          ovf_o,
  output logic          mat_o,
  output logic [CW-1:0] ld_pend_o,
  output logic [CW-1:0] mt_pend_o
);
  logic [CW-1:0] cnt_q, cnt_d, mt_q, mt_d, ldp_q, ldp_d, mtp_q, mtp_d;
  logic          run_q, run_d;

  assign ovf_o = tick_i && (cnt_q == {CW{1'b1}});
  assign mat_o = tick_i && cmp_en_i && (cnt_q == mt_q);

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    mt_d  = mt_q;
    ldp_d = ldp_q;
    mtp_d = mtp_q;
    if (ld_wr_i) begin
      ldp_d = ld_val_i;
      mtp_d = mt_val_i;
    end
    if (!run_q) mt_d = ld_wr_i ? mt_val_i : mtp_q;
    if (ovf_o) begin
      cnt_d = ldp_q;
      mt_d  = mtp_q;
      if (!auto_i) run_d = 1'b0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (cnt_wr_i) cnt_d = cnt_wdata_i;
    if (stop_i)   run_d = 1'b0;
    if (start_i)  run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      mt_q  <= '0;
      ldp_q <= '0;
      mtp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      mt_q  <= mt_d;
      ldp_q <= ldp_d;
      mtp_q <= mtp_d;
    end
  end

  assign run_o     = run_q;
  assign ld_pend_o = ldp_q;
  assign mt_pend_o = mtp_q;

  // R1
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !cnt_wr_i) |=> (cnt_q == $past(ldp_q)));
  // R8
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !auto_i && !start_i) |=> !run_q);
endmodule

// File: rtl/arpwm_wave.sv
module arpwm_wave
  import arpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       pulse_i,
  input  logic       idle_i,
  input  logic [1:0] trig_i,
  input  logic       ovf_i,
  input  logic       mat_i,
  input  logic       ovf_clr_i,
  input  logic       mat_clr_i,
  input  logic       ovf_ie_i,
  input  logic       mat_ie_i,
  output logic       out_o,
  output logic       ovf_flag_o,
  output logic       mat_flag_o,
  output logic       irq_o
);
  trig_e trig;
  logic  evt, out_q, out_d, fo_q, fo_d, fm_q, fm_d;

  always_comb begin
    trig = trig_e'(trig_i);
    evt  = ((trig == TRG_OVF || trig == TRG_BOTH) && ovf_i) ||
           ((trig == TRG_BOTH) && mat_i);
    if (!run_i)       out_d = idle_i;
    else if (pulse_i) out_d = evt ? !idle_i : idle_i;
    else              out_d = evt ? !out_q : out_q;
    fo_d = (fo_q && !ovf_clr_i) || ovf_i;
    fm_d = (fm_q && !mat_clr_i) || mat_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      fo_q  <= 1'b0;
      fm_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      fo_q  <= fo_d;
      fm_q  <= fm_d;
    end
  end

  assign out_o      = out_q;
  assign ovf_flag_o = fo_q;
  assign mat_flag_o = fm_q;
  assign irq_o      = (fo_q && ovf_ie_i) || (fm_q && mat_ie_i);

  // R6
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (out_q == $past(idle_i)));
  // R11
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> fo_q);
  // R11
  mat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mat_i |=> fm_q);
endmodule

// File: rtl/arpwm_timer.sv
module arpwm_timer #(
  parameter int CW   = 32,
  parameter int SELW = 4,
  parameter int NMAX = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            auto_rld,
  input  logic            pre_en,
  input  logic [SELW-1:0] div_sel,
  input  logic            cmp_en,
  input  logic [1:0]      trig_sel,
  input  logic            pulse_mode,
  input  logic            idle_lvl,
  input  logic            ld_wr,
  input  logic [CW-1:0]   ld_val,
  input  logic [CW-1:0]   mt_val,
  input  logic            cnt_wr,
  input  logic [CW-1:0]   cnt_wdata,
  input  logic            ovf_ie,
  input  logic            mat_ie,
  input  logic            ovf_clr,
  input  logic            mat_clr,
  output logic            pwm_out,
  output logic            running,
  output logic            ovf_flag,
  output logic            mat_flag,
  output logic            irq,
  output logic            cfg_err
);
  import arpwm_pkg::*;
  localparam logic [CW:0] LIMIT = {1'b0, {CW{1'b1}}} - 2;

  logic          tick, ovf, mat;
  logic [CW-1:0] ld_pend, mt_pend;

  arpwm_presc #(.SELW(SELW), .NMAX(NMAX)) u_presc (
    .clk(clk), .rst_n(rst_n), .en_i(running), .pre_en_i(pre_en),
    .sel_i(div_sel), .tick_o(tick)
  );

  arpwm_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .stop_i(stop),
    .auto_i(auto_rld), .cmp_en_i(cmp_en), .cnt_wr_i(cnt_wr),
    .cnt_wdata_i(cnt_wdata), .ld_wr_i(ld_wr), .ld_val_i(ld_val),
    .mt_val_i(mt_val), .run_o(running), .ovf_o(ovf), .mat_o(mat),
    .ld_pend_o(ld_pend), .mt_pend_o(mt_pend)
  );

  arpwm_wave u_wave (
    .clk(clk), .rst_n(rst_n), .run_i(running), .pulse_i(pulse_mode),
    .idle_i(idle_lvl), .trig_i(trig_sel), .ovf_i(ovf), .mat_i(mat),
    .ovf_clr_i(ovf_clr), .mat_clr_i(mat_clr), .ovf_ie_i(ovf_ie),
    .mat_ie_i(mat_ie), .out_o(pwm_out), .ovf_flag_o(ovf_flag),
    .mat_flag_o(mat_flag), .irq_o(irq)
  );

  always_comb begin
    cfg_err = ({1'b0, ld_pend} > LIMIT) || ({1'b0, mt_pend} > LIMIT) ||
              ((trig_e'(trig_sel) == TRG_BOTH) &&
               ({1'b0, mt_pend} < ({1'b0, ld_pend} + 2)));
  end

  // R3
  no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |-> !u_wave.mat_i);
endmodule

// File: tb/tb_arpwm_timer.sv
module tb_arpwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TOP = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, auto_rld = 1, pre_en = 0, cmp_en = 0;
  logic [3:0] div_sel = 0;
  logic [1:0] trig_sel = 0;
  logic pulse_mode = 0, idle_lvl = 0, ld_wr = 0, cnt_wr = 0;
  logic [31:0] ld_val = 0, mt_val = 0, cnt_wdata = 0;
  logic ovf_ie = 0, mat_ie = 0, ovf_clr = 0, mat_clr = 0;
  logic pwm_out, running, ovf_flag, mat_flag, irq, cfg_err;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int scen_id = 0, seen_id = 0;
  bit mon_en = 0;
  string cur_req = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  arpwm_timer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .auto_rld(auto_rld),
    .pre_en(pre_en), .div_sel(div_sel), .cmp_en(cmp_en), .trig_sel(trig_sel),
    .pulse_mode(pulse_mode), .idle_lvl(idle_lvl), .ld_wr(ld_wr), .ld_val(ld_val),
    .mt_val(mt_val), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_ie(ovf_ie),
    .mat_ie(mat_ie), .ovf_clr(ovf_clr), .mat_clr(mat_clr), .pwm_out(pwm_out),
    .running(running), .ovf_flag(ovf_flag), .mat_flag(mat_flag), .irq(irq),
    .cfg_err(cfg_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: measures edge-to-edge intervals and pops expected ones
  logic prev = 1'b0;
  bit   have_last = 0;
  int   since = 0;
  always @(negedge clk) begin
    since++;
    if (seen_id != scen_id) begin
      seen_id = scen_id;
      have_last = 0;
      since = 0;
    end else if (mon_en && pwm_out !== prev) begin
      if (have_last && exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        n_chk++;
        if (since != e) begin
          n_fail++;
          $display("FAIL %s interval actual=%0d expected=%0d", cur_req, since, e);
        end
      end
      have_last = 1;
      since = 0;
    end
    prev = pwm_out;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_lm(logic [31:0] l, logic [31:0] m);
    ld_val = l; mt_val = m; ld_wr = 1; step(); ld_wr = 0;
  endtask

  task automatic preload();
    cnt_wdata = 32'hFFFF_FFFE; cnt_wr = 1; step(); cnt_wr = 0;  // R7
  endtask

  task automatic go();
    start = 1; step(); start = 0;
  endtask

  task automatic halt();
    stop = 1; step(); stop = 0; step(2);
  endtask

  task automatic scen_begin(string req);
    cur_req = req; exp_q.delete(); scen_id++; mon_en = 1; step();
  endtask

  task automatic scen_end();
    mon_en = 0; halt();
    chk({cur_req, " all intervals seen"}, exp_q.size(), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R12 reset state
    chk("R12 out", pwm_out, 0);
    chk("R12 running", running, 0);
    chk("R12 flags", {ovf_flag, mat_flag}, 0);
    chk("R12 irq", irq, 0);
    chk("R12 cfg_err", cfg_err, 0);

    // R6 rest level follows idle_lvl while stopped
    idle_lvl = 1; step();
    chk("R6 idle high", pwm_out, 1);
    idle_lvl = 0; step();
    chk("R6 idle low", pwm_out, 0);

    // R1 R7 toggle on overflow only, period 10
    write_lm(TOP - 9, TOP - 6);
    trig_sel = 2'b01;
    scen_begin("R1");
    exp_q.push_back(10); exp_q.push_back(10); exp_q.push_back(10);
    preload(); go(); step(40);
    scen_end();

    // R3 R4 overflow and match, intervals 4 and 6
    cmp_en = 1; trig_sel = 2'b10;
    scen_begin("R3");
    exp_q.push_back(4); exp_q.push_back(6); exp_q.push_back(4); exp_q.push_back(6);
    preload(); go(); step(30);
    scen_end();
    chk("R11 ovf flag set", ovf_flag, 1);
    chk("R11 mat flag set", mat_flag, 1);
    chk("R11 irq masked", irq, 0);
    ovf_ie = 1; step();
    chk("R11 irq ovf", irq, 1);
    ovf_clr = 1; step(); ovf_clr = 0;
    chk("R11 ovf cleared", {ovf_flag, irq}, 2'b00);
    chk("R11 mat kept", mat_flag, 1);
    mat_ie = 1; step();
    chk("R11 irq mat", irq, 1);
    mat_clr = 1; step(); mat_clr = 0;
    chk("R11 mat cleared", {mat_flag, irq}, 2'b00);
    ovf_ie = 0; mat_ie = 0;

    // R3 match gated by cmp_en
    cmp_en = 0;
    scen_begin("R3 gated");
    exp_q.push_back(10); exp_q.push_back(10);
    preload(); go(); step(30);
    scen_end();
    chk("R3 no match flag", mat_flag, 0);

    // R5 pulse mode
    trig_sel = 2'b01; pulse_mode = 1;
    scen_begin("R5");
    exp_q.push_back(1); exp_q.push_back(9); exp_q.push_back(1);
    preload(); go(); step(20);
    scen_end();
    pulse_mode = 0;

    // R4 no events for 00 and 11 (rest level 1 kept)
    idle_lvl = 1;
    foreach (trig_sel[i]) begin end
    for (int t = 0; t < 2; t++) begin
      trig_sel = (t == 0) ? 2'b00 : 2'b11;
      preload(); go(); step(2);
      for (int k = 0; k < 25; k++) begin
        if (pwm_out !== 1'b1) begin
          n_chk++; n_fail++;
          $display("FAIL R4 trig=%0b actual=%0b expected=1", trig_sel, pwm_out);
          break;
        end
        step();
      end
      chk("R4 output held", pwm_out, 1);
      halt();
    end
    idle_lvl = 0; trig_sel = 2'b01; step();

    // R2 prescaler divide by 2
    pre_en = 1; div_sel = 4'd1;
    scen_begin("R2");
    exp_q.push_back(20); exp_q.push_back(20);
    preload(); go(); step(60);
    scen_end();
    pre_en = 0; div_sel = 0;

    // R10 shadowed load change mid-period
    scen_begin("R10");
    exp_q.push_back(10); exp_q.push_back(10); exp_q.push_back(5); exp_q.push_back(5);
    preload(); go(); step(14);
    write_lm(TOP - 4, TOP - 2);
    step(25);
    scen_end();
    write_lm(TOP - 9, TOP - 6);

    // R9 configuration error
    write_lm(TOP - 1, TOP - 6);
    chk("R9 load too high", cfg_err, 1);
    write_lm(TOP - 2, TOP - 2);
    chk("R9 limits ok", cfg_err, 0);
    trig_sel = 2'b10;
    write_lm(TOP - 9, TOP - 8);
    chk("R9 match too close", cfg_err, 1);
    write_lm(TOP - 9, TOP - 7);
    chk("R9 match gap ok", cfg_err, 0);
    trig_sel = 2'b01;

    // R8 one-shot
    ovf_clr = 1; mat_clr = 1; step(); ovf_clr = 0; mat_clr = 0;
    auto_rld = 0;
    preload(); go(); step(6);
    chk("R8 one-shot stopped", running, 0);
    chk("R8 one overflow", ovf_flag, 1);
    chk("R8 rest level", pwm_out, 0);
    auto_rld = 1;
    go(); step(3);
    chk("R8 auto keeps running", running, 1);
    halt();

    summary();
    $finish;
  end
endmodule